// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block moves received frames into memory buffers that software supplies through a circular list of descriptors. Each descriptor names a buffer, gives its size as a negative number, and carries a control byte whose top bit says whether software or the device holds it. When a frame starts, the block reads the current descriptor. If the device holds it, the block writes the frame bytes into the buffer one at a time. When a buffer fills before the frame ends, the frame continues in the next descriptor. The block marks the first and last buffers of the frame, writes the frame length and the error status into the final descriptor, and gives each descriptor back to software by clearing its ownership bit.

Every hand-back raises a one-cycle receive-interrupt pulse. If a frame arrives while the current descriptor belongs to software, the block discards the whole frame and raises a missed-frame pulse. A mode input blocks all access to the ring. While it is set, frames are discarded without any memory traffic. The memory port uses 16-bit words with byte enables and a request/acknowledge handshake.

Top module: `rx_ring_mgr`

## Requirements
- R1: The ring holds 1 << ring_code_i[7:5] entries. Bits [2:0] of ring_base_i are ignored. Descriptor i sits at byte address base + 8*i. After the last entry the index wraps to entry 0.
- R2: Descriptor layout, as little-endian 16-bit words: byte offset 0 holds buffer address bits [15:0]. Offset 2 holds the control byte in lane 0 (bits 7:0) and buffer address bits [23:16] in lane 1. Offset 4 holds the negated buffer size. Offset 6 holds the frame length.
- R3: The device uses a descriptor only when control bit 7 is 1. Frame bytes go to consecutive byte addresses starting at the buffer address. Each byte is one write with mem_be_o = 01 for an even address and 10 for an odd address, and the byte is copied into both lanes of mem_wdata_o.
- R4: A frame longer than its buffer fills that buffer completely and continues in the next descriptor. Control bit 1 is set only in the first buffer of a frame. Control bit 0 is set only in the last buffer. A frame that ends exactly on a full buffer claims no further descriptor.
- R5: The total frame length in bytes is written to offset 6 of the final descriptor only. Earlier buffers of the frame get no length write.
- R6: A descriptor is handed back by a lane-0 write to offset 2 with bit 7 = 0. This write is the last access to that descriptor. rint_o pulses for one cycle with every hand-back.
- R7: In the final descriptor, control bits 5, 4 and 3 take rx_stat_i[2], rx_stat_i[1] and rx_stat_i[0] as sampled with the last byte. Bit 6 is the OR of bits 5 to 2.
- R8: If a buffer fills and the next descriptor has bit 7 = 0, the current descriptor is handed back with bits 2 and 6 set and bit 0 clear. The rest of the frame is discarded, and the index moves on.
- R9: If a frame starts while the current descriptor has bit 7 = 0, the frame is consumed and discarded with no memory writes. miss_o pulses once and the index stays where it was.
- R10: If ring_dis_i is 1 when a frame starts, the frame is consumed with no memory access and no pulses. The index is unchanged.
- R11: After reset there is no request and no pulse. A memory request holds its address and direction stable until mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ring_dis_i | input | 1 | Block ring access, sampled at frame start |
| ring_base_i | input | 24 | Ring base byte address (8-byte aligned) |
| ring_code_i | input | 8 | Ring length code, entries = 1 << [7:5] |
| rx_valid_i | input | 1 | Frame byte valid |
| rx_data_i | input | 8 | Frame byte |
| rx_last_i | input | 1 | Byte is the last of its frame |
| rx_stat_i | input | 3 | Frame status {framing, overflow, crc}, valid with last byte |
| rx_ready_o | output | 1 | Byte accepted when high with rx_valid_i |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 24 | Byte address (even for word accesses) |
| mem_be_o | output | 2 | Byte-lane enables |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Request completed |
| rint_o | output | 1 | Descriptor handed back pulse |
| miss_o | output | 1 | Frame dropped for lack of descriptor pulse |

## Verification
A wrong ring index or buffer offset shows up at the very next memory write as a wrong address. This is either a byte landing outside its buffer or a control write aimed at the wrong descriptor, and it is visible within one access. A lost first-buffer or out-of-buffers flag shows up in the control byte of the hand-back write that closes the buffer. A stale ownership decision shows up one frame later, as a missed-frame pulse that should not occur or one that fails to occur. A frame-length counter that drifts appears only at the end of the frame, in the offset-6 write.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int ADDR_W     = 24;
  localparam int IDX_W      = 7;
  localparam int EXP_W      = 3;
  localparam int LEN_W      = 16;
  localparam int CODE_W     = 8;
  localparam int CODE_SHIFT = 5;

  // control byte bit positions (decoded by software)
  localparam int CTL_OWN  = 7;
  localparam int CTL_ERR  = 6;
  localparam int CTL_FRAM = 5;
  localparam int CTL_OFLO = 4;
  localparam int CTL_CRC  = 3;
  localparam int CTL_BUFF = 2;
  localparam int CTL_STP  = 1;
  localparam int CTL_ENP  = 0;

  // descriptor word offsets in bytes
  localparam int OFS_ADDR = 0;
  localparam int OFS_CTL  = 2;
  localparam int OFS_SIZE = 4;
  localparam int OFS_LEN  = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_RD_LO, S_RD_SZ, S_DATA,
    S_WR_DATA, S_RD_NXT, S_WR_CNT, S_WR_CTL, S_DRAIN
  } state_e;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int AW    = 24,
  parameter int IDX_W = 7,
  parameter int EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    base_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             adv_i,
  output logic [AW-1:0]    cur_addr_o,
  output logic [AW-1:0]    nxt_addr_o
);
  logic [IDX_W-1:0] idx_q, cur, nxt, mask;
  logic [IDX_W:0]   span;
  logic [AW-1:0]    base_al;
  logic             unused_base;

  assign span    = (IDX_W+1)'(1) << exp_i;
  assign mask    = span[IDX_W-1:0] - 1'b1;
  assign cur     = idx_q & mask;
  assign nxt     = (cur + 1'b1) & mask;
  assign base_al = {base_i[AW-1:3], 3'b000};
  assign unused_base = ^base_i[2:0];

  assign cur_addr_o = base_al + AW'({cur, 3'b000});
  assign nxt_addr_o = base_al + AW'({nxt, 3'b000});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= nxt;
  end

  AST_RING_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && (cur == mask) |=> idx_q == '0); // R1
endmodule

// File: rtl/rxr_buf_track.sv
module rxr_buf_track #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             load_i,
  input  logic [LEN_W-1:0] neg_size_i,
  input  logic             byte_i,
  input  logic             chain_i,
  output logic [LEN_W-1:0] off_o,
  output logic [LEN_W-1:0] len_o,
  output logic             fill_o,
  output logic             first_o
);
  logic [LEN_W-1:0] size_q, off_q, len_q;
  logic             first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q  <= '0;
      off_q   <= '0;
      len_q   <= '0;
      first_q <= 1'b0;
    end else begin
      if (start_i) begin
        len_q   <= '0;
        first_q <= 1'b1;
      end
      if (chain_i) first_q <= 1'b0;
      if (load_i) begin
        size_q <= '0 - neg_size_i;
        off_q  <= '0;
      end
      if (byte_i) begin
        off_q <= off_q + 1'b1;
        len_q <= len_q + 1'b1;
      end
    end
  end

  assign off_o   = off_q;
  assign len_o   = len_q;
  assign fill_o  = (off_q + 1'b1) == size_q;
  assign first_o = first_q;

  AST_LEN_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i && !start_i |=> len_q == $past(len_q) + 1'b1); // R5
  AST_LOAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !byte_i |=> off_q == '0); // R3
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rxr_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int IW    = IDX_W,
  parameter int EW    = EXP_W,
  parameter int LW    = LEN_W,
  parameter int CW    = CODE_W,
  parameter int SHIFT = CODE_SHIFT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ring_dis_i,
  input  logic [AW-1:0] ring_base_i,
  input  logic [CW-1:0] ring_code_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_last_i,
  input  logic [2:0]    rx_stat_i,
  output logic          rx_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_be_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          rint_o,
  output logic          miss_o
);
  localparam int HI_W = AW - 16;

  state_e           state_q, state_d;
  logic [15:0]      lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [7:0]       byte_q;
  logic             last_q, buff_q, dis_q;
  logic [2:0]       stat_q;
  logic [AW-1:0]    cur_addr, nxt_addr, buf_addr;
  logic [LW-1:0]    off, len;
  logic             fill, first;
  logic             own_rd, adv, start, load, byte_wr, chain;
  logic [7:0]       ctl;
  logic             unused_code;

  assign unused_code = ^ring_code_i[SHIFT-1:0];
  assign own_rd      = mem_rdata_i[CTL_OWN];

  rxr_ring_ptr #(.AW(AW), .IDX_W(IW), .EXP_W(EW)) u_ptr (
    .clk_i, .rst_ni,
    .base_i     (ring_base_i),
    .exp_i      (ring_code_i[SHIFT +: EW]),
    .adv_i      (adv),
    .cur_addr_o (cur_addr),
    .nxt_addr_o (nxt_addr)
  );

  rxr_buf_track #(.LEN_W(LW)) u_trk (
    .clk_i, .rst_ni,
    .start_i    (start),
    .load_i     (load),
    .neg_size_i (mem_rdata_i[LW-1:0]),
    .byte_i     (byte_wr),
    .chain_i    (chain),
    .off_o      (off),
    .len_o      (len),
    .fill_o     (fill),
    .first_o    (first)
  );

  assign buf_addr = {hi_q, lo_q} + AW'(off);

  always_comb begin
    ctl            = '0;
    ctl[CTL_STP]   = first;
    ctl[CTL_ENP]   = last_q;
    ctl[CTL_BUFF]  = buff_q;
    if (last_q) {ctl[CTL_FRAM], ctl[CTL_OFLO], ctl[CTL_CRC]} = stat_q;
    ctl[CTL_ERR]   = |{ctl[CTL_FRAM], ctl[CTL_OFLO], ctl[CTL_CRC], ctl[CTL_BUFF]};
  end

  assign start   = (state_q == S_IDLE) && rx_valid_i && !ring_dis_i;
  assign load    = (state_q == S_RD_SZ) && mem_ack_i;
  assign byte_wr = (state_q == S_WR_DATA) && mem_ack_i;
  assign adv     = (state_q == S_WR_CTL) && mem_ack_i;
  assign chain   = adv && !last_q && !buff_q;
  assign rint_o  = adv;
  assign miss_o  = (state_q == S_RD_CTL) && mem_ack_i && !own_rd;
  assign rx_ready_o = (state_q == S_DATA) || (state_q == S_DRAIN);

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = 2'b11;
    mem_wdata_o = '0;
    unique case (state_q)
      S_RD_CTL:  mem_addr_o = cur_addr + AW'(OFS_CTL);
      S_RD_LO:   mem_addr_o = cur_addr + AW'(OFS_ADDR);
      S_RD_SZ:   mem_addr_o = cur_addr + AW'(OFS_SIZE);
      S_RD_NXT:  mem_addr_o = nxt_addr + AW'(OFS_CTL);
      S_WR_DATA: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_addr;
        mem_be_o    = buf_addr[0] ? 2'b10 : 2'b01;
        mem_wdata_o = {byte_q, byte_q};
      end
      S_WR_CNT: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_addr + AW'(OFS_LEN);
        mem_wdata_o = 16'(len);
      end
      S_WR_CTL: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_addr + AW'(OFS_CTL);
        mem_be_o    = 2'b01;
        mem_wdata_o = {8'h00, ctl};
      end
      default: begin
        mem_req_o = 1'b0;
        mem_be_o  = 2'b00;
      end
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (rx_valid_i) state_d = ring_dis_i ? S_DRAIN : S_RD_CTL;
      S_RD_CTL:  if (mem_ack_i) state_d = own_rd ? S_RD_LO : S_DRAIN;
      S_RD_LO:   if (mem_ack_i) state_d = S_RD_SZ;
      S_RD_SZ:   if (mem_ack_i) state_d = S_DATA;
      S_DATA:    if (rx_valid_i) state_d = S_WR_DATA;
      S_WR_DATA: if (mem_ack_i) state_d = last_q ? S_WR_CNT : (fill ? S_RD_NXT : S_DATA);
      S_RD_NXT:  if (mem_ack_i) state_d = S_WR_CTL;
      S_WR_CNT:  if (mem_ack_i) state_d = S_WR_CTL;
      S_WR_CTL:  if (mem_ack_i) state_d = last_q ? S_IDLE : (buff_q ? S_DRAIN : S_RD_LO);
      S_DRAIN:   if (rx_valid_i && rx_last_i) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      lo_q    <= '0;
      hi_q    <= '0;
      byte_q  <= '0;
      last_q  <= 1'b0;
      stat_q  <= '0;
      buff_q  <= 1'b0;
      dis_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && rx_valid_i) begin
        dis_q  <= ring_dis_i;
        buff_q <= 1'b0;
        last_q <= 1'b0;
      end
      if (state_q == S_DRAIN && rx_valid_i && rx_last_i) dis_q <= 1'b0;
      if (state_q == S_RD_CTL && mem_ack_i) hi_q <= mem_rdata_i[15 -: HI_W];
      if (state_q == S_RD_LO && mem_ack_i) lo_q <= mem_rdata_i;
      if (state_q == S_DATA && rx_valid_i) begin
        byte_q <= rx_data_i;
        last_q <= rx_last_i;
        stat_q <= rx_stat_i;
      end
      if (state_q == S_RD_NXT && mem_ack_i) begin
        buff_q <= !own_rd;
        if (own_rd) hi_q <= mem_rdata_i[15 -: HI_W];
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R11
  AST_OWN_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rint_o |-> mem_we_o && mem_be_o == 2'b01 && !mem_wdata_o[CTL_OWN]); // R6
  AST_ERR_SUMMARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rint_o |-> mem_wdata_o[CTL_ERR] == |mem_wdata_o[CTL_FRAM:CTL_BUFF]); // R7
  AST_BUFF_NOT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rint_o && mem_wdata_o[CTL_BUFF] |-> !mem_wdata_o[CTL_ENP]); // R8
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |=> !mem_req_o && rx_ready_o); // R9
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_q |-> !mem_req_o && !rint_o && !miss_o); // R10
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rint_o, miss_o})); // R6
endmodule

// File: tb/rx_ring_mgr_test.sv
module rx_ring_mgr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ring_dis = 1'b0;
  logic [23:0] ring_base = 24'h000043;
  logic [7:0]  ring_code = 8'h40;   // 4 entries
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic [2:0]  rx_stat = '0;
  logic        rx_ready, mem_req, mem_we, mem_ack, rint, miss;
  logic [23:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  rx_ring_mgr uut (
    .clk_i(clk), .rst_ni(rst_n), .ring_dis_i(ring_dis), .ring_base_i(ring_base),
    .ring_code_i(ring_code), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .rx_stat_i(rx_stat), .rx_ready_o(rx_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ack_i(mem_ack), .rint_o(rint), .miss_o(miss)
  );

  int checks = 0;
  int errors = 0;
  int rint_cnt = 0, miss_cnt = 0, exp_rint = 0, exp_miss = 0;
  int cycles = 0;
  bit done = 0;

  logic [41:0] exp_q[$];
  string       tag_q[$];

  logic [15:0] mem [0:1023];
  logic        host_we = 1'b0;
  logic [23:0] host_addr = '0;
  logic [15:0] host_data = '0;
  logic        phase = 1'b0, stalled = 1'b0;
  logic [23:0] lat_addr = '0;

  bit          own_s [0:3];
  int          size_s [0:3];
  int          idx_s = 0;

  function automatic logic [23:0] desc_a(int i);
    return 24'h000040 + 24'(8 * i);
  endfunction
  function automatic logic [23:0] buf_a(int i);
    return 24'h000101 + 24'(64 * i);
  endfunction
  function automatic logic [7:0] ctl_exp(bit first, bit last, bit buff, logic [2:0] st);
    logic [7:0] b;
    b = '0;
    b[1] = first; b[0] = last; b[2] = buff;
    if (last) b[5:3] = st;
    b[6] = |b[5:2];
    return b;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // memory responder + scoreboard monitor
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (host_we) mem[host_addr[10:1]] <= host_data;
    if (rint) rint_cnt++;
    if (miss) miss_cnt++;
    if (rst_n && mem_req && !mem_ack) begin
      if (phase && !stalled) begin
        stalled  <= 1'b1;
        lat_addr <= mem_addr;
      end else begin
        mem_ack <= 1'b1;
        stalled <= 1'b0;
        phase   <= ~phase;
        if (stalled) check(lat_addr == mem_addr, "R11", "address held", mem_addr, lat_addr);
        if (mem_we) begin
          logic [15:0] m;
          m = {{8{mem_be[1]}}, {8{mem_be[0]}}};
          if (mem_be[0]) mem[mem_addr[10:1]][7:0]  <= mem_wdata[7:0];
          if (mem_be[1]) mem[mem_addr[10:1]][15:8] <= mem_wdata[15:8];
          if (exp_q.size() == 0) begin
            check(0, "R3", "unexpected write", {mem_addr, mem_be, mem_wdata}, 0);
          end else begin
            logic [41:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(mem_addr == e[41:18] && mem_be == e[17:16] &&
                  (mem_wdata & m) == (e[15:0] & m), t, "write",
                  {mem_addr, mem_be, mem_wdata & m}, e);
          end
        end else begin
          mem_rdata <= mem[mem_addr[10:1]];
        end
      end
    end
  end

  task automatic push(logic [23:0] a, logic [1:0] be, logic [15:0] d, string t);
    exp_q.push_back({a, be, d});
    tag_q.push_back(t);
  endtask

  task automatic host_wr(logic [23:0] a, logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_desc(int i, bit own, int size);
    logic [23:0] b;
    b = buf_a(i);
    host_wr(desc_a(i) + 0, b[15:0]);
    host_wr(desc_a(i) + 2, {b[23:16], own ? 8'h80 : 8'h00});
    host_wr(desc_a(i) + 4, 16'(-size));
    host_wr(desc_a(i) + 6, 16'hdead);
    own_s[i]  = own;
    size_s[i] = size;
  endtask

  task automatic send_frame(int len, logic [7:0] seed, logic [2:0] st, string tag);
    int cur, off, nxt;
    bit first;
    if (!ring_dis) begin
      cur = idx_s;
      if (!own_s[cur]) exp_miss++;
      else begin
        first = 1; off = 0;
        for (int k = 0; k < len; k++) begin
          logic [23:0] a;
          logic [7:0]  b;
          a = buf_a(cur) + 24'(off);
          b = seed + 8'(k);
          push(a, a[0] ? 2'b10 : 2'b01, {b, b}, "R3");
          off++;
          if (k == len - 1) begin
            push(desc_a(cur) + 6, 2'b11, 16'(len), "R5");
            push(desc_a(cur) + 2, 2'b01, {8'h00, ctl_exp(first, 1, 0, st)}, "R7");
            own_s[cur] = 0; exp_rint++; idx_s = (cur + 1) % 4;
            break;
          end else if (off == size_s[cur]) begin
            nxt = (cur + 1) % 4;
            if (own_s[nxt]) begin
              push(desc_a(cur) + 2, 2'b01, {8'h00, ctl_exp(first, 0, 0, st)}, "R4");
              own_s[cur] = 0; exp_rint++; cur = nxt; idx_s = nxt; first = 0; off = 0;
            end else begin
              push(desc_a(cur) + 2, 2'b01, {8'h00, ctl_exp(first, 0, 1, st)}, "R8");
              own_s[cur] = 0; exp_rint++; idx_s = nxt;
              break;
            end
          end
        end
      end
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = seed + 8'(k); rx_last = (k == len - 1);
      rx_stat = (k == len - 1) ? st : 3'b000;
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, tag, "pending writes", exp_q.size(), 0);
    check(rint_cnt == exp_rint, "R6", "rint pulses", rint_cnt, exp_rint);
    check(miss_cnt == exp_miss, "R9", "miss pulses", miss_cnt, exp_miss);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    check(!mem_req && !rint && !miss && !rx_ready, "R11", "reset idle",
          {mem_req, rint, miss, rx_ready}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) set_desc(i, 1, 8);
    check(!mem_req, "R11", "idle without frame", mem_req, 0);

    send_frame(5, 8'h10, 3'b000, "R3");      // single buffer
    send_frame(20, 8'h40, 3'b001, "R4");     // three buffers, crc flag
    send_frame(4, 8'h70, 3'b000, "R9");      // desc0 software owned: missed

    set_desc(0, 1, 8);
    set_desc(1, 1, 8);
    send_frame(8, 8'h80, 3'b110, "R4");      // exact fill, no chaining
    check(mem[(24'h42) >> 1][7:0] == ctl_exp(1, 1, 0, 3'b110), "R2", "desc0 control",
          mem[(24'h42) >> 1][7:0], ctl_exp(1, 1, 0, 3'b110));

    send_frame(12, 8'h90, 3'b000, "R8");     // desc2 not owned: out of buffers

    set_desc(2, 1, 8);
    ring_dis = 1'b1;
    send_frame(4, 8'hA0, 3'b000, "R10");     // ring blocked
    ring_dis = 1'b0;
    send_frame(3, 8'hB0, 3'b100, "R10");     // lands in desc2: index unchanged

    set_desc(3, 1, 4);
    set_desc(0, 1, 8);
    send_frame(6, 8'hC0, 3'b010, "R1");      // chain across the wrap
    check(mem[(24'h46) >> 1] == 16'd6, "R1", "wrapped desc0 length",
          mem[(24'h46) >> 1], 6);
    check(mem[(24'h5E) >> 1] == 16'hdead, "R5", "non-final length untouched",
          mem[(24'h5E) >> 1], 16'hdead);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule